// File: doc/BRIEF.md
# Co-issue dependency and forwarding gate

This block decides, within one cycle and with no state, how many instructions of an eight-wide in-order issue group may go together. Each slot comes with a decoded descriptor: a valid bit, a format class, a destination register, three source registers, an ALU flag and a flags-only flag. Slot 0 is the oldest. Every younger slot is compared with every older slot for read-after-write dependencies. A dependency is tolerated only when a same-cycle ALU-to-ALU bypass is allowed for that producer/consumer pair. That bypass may be taken only one hop deep.

The gate produces three results: a per-slot grant, a per-slot flag telling that the slot issues on a bypassed value, and the number of slots issued. Issue is strictly in order. The first refused slot stops the rest of the group, so the count equals the length of the granted prefix. Register 31 is the zero register. It is never a producer, and reading it never creates a dependency.

Top module: `iss_cogate`

## Requirements
- R1: Slot 0 is granted exactly when it is valid, and its forwarded flag is always 0.
- R2: A younger slot that reads the destination of an older valid slot is refused unless a bypass is allowed for that pair.
- R3: Valid slots with no dependency on older slots are all granted. A destination of 31 never produces a dependency, even when a younger slot reads register 31.
- R4: A bypass requires the producer's ALU flag. With a non-ALU producer, a dependent slot is refused whatever the formats are.
- R5: Format codes are 0 other, 1 immediate arithmetic, 2 register arithmetic, 3 three-source (multiply-add class) and 4 bitfield/shift. A bypass is allowed when the producer's format is 3 or 4, or when the consumer's format is 3.
- R6: A bypass is also allowed when the consumer has format 1, the flags-only bit set and destination 31. With any other destination the same consumer does not get this allowance.
- R7: All other pairs get no bypass. For example, a format-1 producer feeding a format-1 consumer is refused, and so is a format-2 producer feeding a format-2 consumer.
- R8: A producer whose own forwarded flag is set cannot bypass to a younger slot in the same group, so a chain of three dependent slots stops at the third.
- R9: The third source is compared only when the consumer has format 3. For other formats it is ignored.
- R10: Once a slot is refused or invalid, every younger slot is refused in that group.
- R11: The forwarded flag of a slot is 1 exactly when the slot is granted and depends on at least one older slot.
- R12: The issue count equals the number of consecutive granted slots starting from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_valid | input | NUM_SLOTS | Descriptor valid, bit i for slot i |
| slot_fmt | input | 3*NUM_SLOTS | Format class per slot (3-bit field i) |
| slot_dst | input | REG_W*NUM_SLOTS | Destination register per slot |
| slot_src_a | input | REG_W*NUM_SLOTS | First source per slot |
| slot_src_b | input | REG_W*NUM_SLOTS | Second source per slot |
| slot_src_c | input | REG_W*NUM_SLOTS | Third (accumulator) source per slot |
| slot_alu | input | NUM_SLOTS | Slot is an ALU operation |
| slot_flags_only | input | NUM_SLOTS | Slot writes only condition flags |
| issue_grant | output | NUM_SLOTS | Slot issues this cycle |
| issue_fwd | output | NUM_SLOTS | Slot issues using a same-cycle bypass |
| issue_count | output | CNT_W | Number of slots issued |

## Verification
Some properties are checked on every input change: the granted slots form a prefix, slot 0 follows its valid bit, a forwarded flag implies a grant, the count matches the number of grants, and no granted slot consumes the result of a slot that was itself forwarded. The format-pair policy can only be shown by the directed scenarios. These cover which pairs get a bypass, the zero-register compare exception, the ALU-producer requirement, and when the third source counts. Each scenario carries expected grants that were worked out by hand.

// File: rtl/iss_gate_pkg.sv
package iss_gate_pkg;
  localparam int FMT_W = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_OTHER     = 3'd0,
    FMT_IMM_ARITH = 3'd1,
    FMT_REG_ARITH = 3'd2,
    FMT_THREE_SRC = 3'd3,
    FMT_BITFIELD  = 3'd4
  } fmt_e;

  // Format policy for a same-cycle bypass between a producer and a consumer.
  function automatic logic fmt_pair_allows(input fmt_e prod, input fmt_e cons,
                                           input logic cons_flags, input logic cons_dst_zero);
    logic ok;
    ok = (prod == FMT_THREE_SRC) || (prod == FMT_BITFIELD) || (cons == FMT_THREE_SRC);
    ok = ok || ((cons == FMT_IMM_ARITH) && cons_flags && cons_dst_zero);
    return ok;
  endfunction
endpackage

// File: rtl/iss_pair_eval.sv
module iss_pair_eval
  import iss_gate_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             p_valid,
  input  logic [REG_W-1:0] p_dst,
  input  logic             p_alu,
  input  fmt_e             p_fmt,
  input  fmt_e             c_fmt,
  input  logic [REG_W-1:0] c_dst,
  input  logic             c_flags,
  input  logic [REG_W-1:0] c_src_a,
  input  logic [REG_W-1:0] c_src_b,
  input  logic [REG_W-1:0] c_src_c,
  output logic             raw_hit,
  output logic             bypass_fmt_ok
);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  logic prod_real;
  logic use_c;

  assign prod_real = p_valid && (p_dst != ZERO_REG);
  assign use_c     = (c_fmt == FMT_THREE_SRC);
  assign raw_hit   = prod_real && ((c_src_a == p_dst) || (c_src_b == p_dst) ||
                                   (use_c && (c_src_c == p_dst)));
  assign bypass_fmt_ok = p_alu && fmt_pair_allows(p_fmt, c_fmt, c_flags, c_dst == ZERO_REG);
endmodule

// File: rtl/iss_lead_count.sv
module iss_lead_count #(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_in,
  output logic [CNT_W-1:0] lead_ones
);
  always_comb begin
    logic run;
    run = 1'b1;
    lead_ones = '0;
    for (int i = 0; i < N; i++) begin
      run = run && bits_in[i];
      if (run) lead_ones = lead_ones + 1'b1;
    end
  end
endmodule

// File: rtl/iss_cogate.sv
module iss_cogate
  import iss_gate_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int REG_W     = 5,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic [NUM_SLOTS-1:0]       slot_valid,
  input  logic [FMT_W*NUM_SLOTS-1:0] slot_fmt,
  input  logic [REG_W*NUM_SLOTS-1:0] slot_dst,
  input  logic [REG_W*NUM_SLOTS-1:0] slot_src_a,
  input  logic [REG_W*NUM_SLOTS-1:0] slot_src_b,
  input  logic [REG_W*NUM_SLOTS-1:0] slot_src_c,
  input  logic [NUM_SLOTS-1:0]       slot_alu,
  input  logic [NUM_SLOTS-1:0]       slot_flags_only,
  output logic [NUM_SLOTS-1:0]       issue_grant,
  output logic [NUM_SLOTS-1:0]       issue_fwd,
  output logic [CNT_W-1:0]           issue_count
);
  localparam int PAIRS = NUM_SLOTS * NUM_SLOTS;

  // Pair matrices, index consumer*NUM_SLOTS + producer; only producer < consumer is live.
  logic [PAIRS-1:0]     raw_flat;
  logic [PAIRS-1:0]     fmt_ok_flat;
  logic [NUM_SLOTS-1:0] slot_blocked;

  for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_cons
    for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_prod
      if (p < c) begin : g_live
        iss_pair_eval #(.REG_W(REG_W)) pair_i (
          .p_valid      (slot_valid[p]),
          .p_dst        (slot_dst[p*REG_W +: REG_W]),
          .p_alu        (slot_alu[p]),
          .p_fmt        (fmt_e'(slot_fmt[p*FMT_W +: FMT_W])),
          .c_fmt        (fmt_e'(slot_fmt[c*FMT_W +: FMT_W])),
          .c_dst        (slot_dst[c*REG_W +: REG_W]),
          .c_flags      (slot_flags_only[c]),
          .c_src_a      (slot_src_a[c*REG_W +: REG_W]),
          .c_src_b      (slot_src_b[c*REG_W +: REG_W]),
          .c_src_c      (slot_src_c[c*REG_W +: REG_W]),
          .raw_hit      (raw_flat[c*NUM_SLOTS + p]),
          .bypass_fmt_ok(fmt_ok_flat[c*NUM_SLOTS + p])
        );
      end else begin : g_dead
        assign raw_flat[c*NUM_SLOTS + p]    = 1'b0;
        assign fmt_ok_flat[c*NUM_SLOTS + p] = 1'b0;
      end
    end
  end

  // Ordered sweep: a producer's own forwarded flag is known before younger slots need it.
  always_comb begin
    logic prev_grant;
    logic any_raw;
    logic blk;
    issue_grant  = '0;
    issue_fwd    = '0;
    slot_blocked = '0;
    prev_grant   = 1'b1;
    for (int c = 0; c < NUM_SLOTS; c++) begin
      any_raw = 1'b0;
      blk     = 1'b0;
      for (int p = 0; p < c; p++) begin
        if (raw_flat[c*NUM_SLOTS + p]) begin
          any_raw = 1'b1;
          if (!(fmt_ok_flat[c*NUM_SLOTS + p] && !issue_fwd[p])) blk = 1'b1;
        end
      end
      slot_blocked[c] = blk;
      issue_grant[c]  = prev_grant && slot_valid[c] && !blk;
      issue_fwd[c]    = issue_grant[c] && any_raw;
      prev_grant      = issue_grant[c];
    end
  end

  iss_lead_count #(.N(NUM_SLOTS), .CNT_W(CNT_W)) count_i (
    .bits_in  (issue_grant),
    .lead_ones(issue_count)
  );
endmodule

// File: rtl/iss_cogate_chk.sv
module iss_cogate_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int REG_W     = 5,
  parameter int CNT_W     = 4
) (
  input logic [NUM_SLOTS-1:0]       slot_valid,
  input logic [3*NUM_SLOTS-1:0]     slot_fmt,
  input logic [REG_W*NUM_SLOTS-1:0] slot_dst,
  input logic [REG_W*NUM_SLOTS-1:0] slot_src_a,
  input logic [REG_W*NUM_SLOTS-1:0] slot_src_b,
  input logic [REG_W*NUM_SLOTS-1:0] slot_src_c,
  input logic [NUM_SLOTS-1:0]       issue_grant,
  input logic [NUM_SLOTS-1:0]       issue_fwd,
  input logic [CNT_W-1:0]           issue_count
);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  always_comb begin
    a_r1_oldest: assert ((issue_grant[0] == slot_valid[0]) && !issue_fwd[0])
      else $error("R1 oldest slot grant/forward wrong");
    a_r12_count: assert (issue_count == CNT_W'($countones(issue_grant)))
      else $error("R12 count does not match grants");
    a_r11_fwd_granted: assert ((issue_fwd & ~issue_grant) == '0)
      else $error("R11 forwarded flag on refused slot");
    for (int i = 1; i < NUM_SLOTS; i++) begin
      a_r10_in_order: assert (!issue_grant[i] || issue_grant[i-1])
        else $error("R10 grant after a refused slot");
    end
    for (int i = 1; i < NUM_SLOTS; i++) begin
      for (int j = 0; j < i; j++) begin
        logic [REG_W-1:0] d;
        logic hit;
        d = slot_dst[j*REG_W +: REG_W];
        hit = (d != ZERO_REG) &&
              ((slot_src_a[i*REG_W +: REG_W] == d) || (slot_src_b[i*REG_W +: REG_W] == d) ||
               ((slot_fmt[i*3 +: 3] == 3'd3) && (slot_src_c[i*REG_W +: REG_W] == d)));
        a_r8_one_hop: assert (!(issue_grant[i] && issue_fwd[j] && hit))
          else $error("R8 two-hop bypass granted");
      end
    end
  end
endmodule

bind iss_cogate iss_cogate_chk #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W), .CNT_W(CNT_W)) chk_i (
  .slot_valid (slot_valid),
  .slot_fmt   (slot_fmt),
  .slot_dst   (slot_dst),
  .slot_src_a (slot_src_a),
  .slot_src_b (slot_src_b),
  .slot_src_c (slot_src_c),
  .issue_grant(issue_grant),
  .issue_fwd  (issue_fwd),
  .issue_count(issue_count)
);

// File: tb/iss_cogate_tb.sv
module iss_cogate_tb_top;
  localparam int N  = 8;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           v   [N];
  logic [2:0]     f   [N];
  logic [RW-1:0]  d   [N];
  logic [RW-1:0]  sa  [N];
  logic [RW-1:0]  sb  [N];
  logic [RW-1:0]  sc  [N];
  logic           alu [N];
  logic           fo  [N];

  logic [N-1:0]    slot_valid, slot_alu, slot_flags_only;
  logic [3*N-1:0]  slot_fmt;
  logic [RW*N-1:0] slot_dst, slot_src_a, slot_src_b, slot_src_c;
  logic [N-1:0]    issue_grant, issue_fwd;
  logic [3:0]      issue_count;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      slot_valid[i]           = v[i];
      slot_alu[i]             = alu[i];
      slot_flags_only[i]      = fo[i];
      slot_fmt[i*3 +: 3]      = f[i];
      slot_dst[i*RW +: RW]    = d[i];
      slot_src_a[i*RW +: RW]  = sa[i];
      slot_src_b[i*RW +: RW]  = sb[i];
      slot_src_c[i*RW +: RW]  = sc[i];
    end
  end

  iss_cogate dut_i (
    .slot_valid(slot_valid), .slot_fmt(slot_fmt), .slot_dst(slot_dst),
    .slot_src_a(slot_src_a), .slot_src_b(slot_src_b), .slot_src_c(slot_src_c),
    .slot_alu(slot_alu), .slot_flags_only(slot_flags_only),
    .issue_grant(issue_grant), .issue_fwd(issue_fwd), .issue_count(issue_count)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      v[i] = 0; f[i] = 3'd0; d[i] = 5'd31; sa[i] = 5'd31; sb[i] = 5'd31;
      sc[i] = 5'd31; alu[i] = 0; fo[i] = 0;
    end
  endtask

  task automatic put(int i, logic [2:0] fm, logic [4:0] dd, logic [4:0] a, logic [4:0] b,
                     logic [4:0] c, logic al, logic fl);
    v[i] = 1; f[i] = fm; d[i] = dd; sa[i] = a; sb[i] = b; sc[i] = c; alu[i] = al; fo[i] = fl;
  endtask

  task automatic expect_out(string tag, logic [7:0] eg, logic [7:0] ef, int ec);
    @(posedge clk); #2;
    checks++;
    if (issue_grant !== eg || issue_fwd !== ef || issue_count !== 4'(ec)) begin
      fails++;
      $display("FAIL %s: grant=%b fwd=%b cnt=%0d expected grant=%b fwd=%b cnt=%0d",
               tag, issue_grant, issue_fwd, issue_count, eg, ef, ec);
    end
  endtask

  task automatic t_empty();
    clear_all();
    expect_out("R1 R12 empty group", 8'h00, 8'h00, 0);
    put(0, 3'd2, 5'd1, 5'd2, 5'd3, 5'd31, 1, 0);
    expect_out("R1 lone oldest slot", 8'h01, 8'h00, 1);
  endtask

  task automatic t_independent();
    clear_all();
    for (int i = 0; i < N; i++) put(i, 3'd1, 5'(i + 1), 5'd20, 5'd21, 5'd31, 1, 0);
    expect_out("R3 eight independent", 8'hFF, 8'h00, 8);
    clear_all();
    put(0, 3'd1, 5'd31, 5'd20, 5'd31, 5'd31, 1, 0);
    put(1, 3'd1, 5'd4, 5'd31, 5'd31, 5'd31, 1, 0);
    expect_out("R3 zero register not a producer", 8'h03, 8'h00, 2);
  endtask

  task automatic t_disallowed();
    clear_all();
    put(0, 3'd1, 5'd1, 5'd20, 5'd31, 5'd31, 1, 0);
    put(1, 3'd1, 5'd2, 5'd1, 5'd31, 5'd31, 1, 0);
    put(2, 3'd1, 5'd3, 5'd22, 5'd31, 5'd31, 1, 0);
    expect_out("R7 R2 R10 imm->imm refused", 8'h01, 8'h00, 1);
    clear_all();
    put(0, 3'd2, 5'd1, 5'd20, 5'd21, 5'd31, 1, 0);
    put(1, 3'd2, 5'd2, 5'd20, 5'd1, 5'd31, 1, 0);
    expect_out("R7 reg->reg refused", 8'h01, 8'h00, 1);
  endtask

  task automatic t_allowed();
    clear_all();
    put(0, 3'd3, 5'd1, 5'd20, 5'd21, 5'd22, 1, 0);
    put(1, 3'd2, 5'd2, 5'd1, 5'd23, 5'd31, 1, 0);
    put(2, 3'd1, 5'd3, 5'd24, 5'd31, 5'd31, 1, 0);
    expect_out("R5 R11 three-src producer", 8'h07, 8'h02, 3);
    clear_all();
    put(0, 3'd4, 5'd5, 5'd20, 5'd31, 5'd31, 1, 0);
    put(1, 3'd2, 5'd6, 5'd20, 5'd5, 5'd31, 1, 0);
    expect_out("R5 bitfield producer", 8'h03, 8'h02, 2);
    clear_all();
    put(0, 3'd1, 5'd7, 5'd20, 5'd31, 5'd31, 1, 0);
    put(1, 3'd3, 5'd8, 5'd7, 5'd21, 5'd22, 1, 0);
    expect_out("R5 three-src consumer", 8'h03, 8'h02, 2);
  endtask

  task automatic t_non_alu();
    clear_all();
    put(0, 3'd3, 5'd1, 5'd20, 5'd21, 5'd22, 0, 0);
    put(1, 3'd3, 5'd2, 5'd1, 5'd21, 5'd22, 1, 0);
    expect_out("R4 non-ALU producer", 8'h01, 8'h00, 1);
  endtask

  task automatic t_compare();
    clear_all();
    put(0, 3'd2, 5'd1, 5'd20, 5'd21, 5'd31, 1, 0);
    put(1, 3'd1, 5'd31, 5'd1, 5'd31, 5'd31, 1, 1);
    expect_out("R6 flags compare to zero reg", 8'h03, 8'h02, 2);
    d[1] = 5'd9;
    expect_out("R6 flags op with real dst", 8'h01, 8'h00, 1);
  endtask

  task automatic t_one_hop();
    clear_all();
    put(0, 3'd3, 5'd1, 5'd20, 5'd21, 5'd22, 1, 0);
    put(1, 3'd4, 5'd2, 5'd1, 5'd31, 5'd31, 1, 0);
    put(2, 3'd2, 5'd3, 5'd2, 5'd23, 5'd31, 1, 0);
    expect_out("R8 chain of three stops", 8'h03, 8'h02, 2);
    sa[2] = 5'd1;
    expect_out("R8 direct from first producer", 8'h07, 8'h06, 3);
  endtask

  task automatic t_third_src();
    clear_all();
    put(0, 3'd2, 5'd3, 5'd20, 5'd21, 5'd31, 0, 0);
    put(1, 3'd3, 5'd4, 5'd22, 5'd23, 5'd3, 1, 0);
    expect_out("R9 accumulator dependency", 8'h01, 8'h00, 1);
    f[1] = 3'd2;
    expect_out("R9 third source ignored", 8'h03, 8'h00, 2);
  endtask

  task automatic t_gap();
    clear_all();
    for (int i = 0; i < N; i++) put(i, 3'd1, 5'(i + 1), 5'd20, 5'd21, 5'd31, 1, 0);
    v[2] = 0;
    expect_out("R10 R12 invalid slot stops group", 8'h03, 8'h00, 2);
  endtask

  initial begin
    clear_all();
    repeat (2) @(posedge clk);
    t_empty();
    t_independent();
    t_disallowed();
    t_allowed();
    t_non_alu();
    t_compare();
    t_one_hop();
    t_third_src();
    t_gap();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule